// File: doc/BRIEF.md
# Clock Health Status Register

This block watches a PCM bit clock and a frame sync. Both arrive with no fixed phase to a free-running reference clock. A PLL lock level comes in as a separate input. All three are brought into the reference domain, and the block folds them into one 8-bit status word. The upper three bits are sticky fault flags. A flag latches when its health condition drops from good to bad. Software clears a flag by writing a 1 to its position. The lower five bits are live, read-only indications.

The bit-clock check counts bit-clock rising edges over a fixed window of reference cycles and compares the count with a threshold. The threshold is the number of edges a 128 kHz clock gives in that window. The frame check has two parts:

- A watchdog timer declares the frame sync missing after a timeout with no frame edge.
- A ratio check counts bit-clock edges per frame. It accepts the count only when it is a power of two within a configured range and equal to the count of the previous frame.

The register sits at one address on a plain register port. Reads return the word combinationally, and writes take effect at the next clock edge. The block has no streaming data path, so every port is a plain control or status pin with no valid/ready handshake and no back-pressure.

Top module: `clk_health_status`

## Requirements
- R1: The status word has this layout:
  - Bit 7 is the PLL fault and bit 6 is the frame fault.
  - Bit 5 is the bit-clock fault and bit 4 is the SRAM-clear done flag.
  - Bit 3 is PLL lock and bit 2 is ratio OK.
  - Bit 1 is frame valid and bit 0 is bit-clock valid.
- R2: After reset the status word reads 0x00.
- R3: Bits 4 to 0 are read-only. Writing any value to them has no effect.
- R4: Bit-clock valid is 1 only when the last completed window of WINDOW_CYC reference cycles held at least MIN_EDGES bit-clock rising edges. A count exactly equal to MIN_EDGES counts as valid.
- R5: Frame valid becomes 1 on a frame-sync rising edge. It returns to 0 once FS_TIMEOUT_CYC reference cycles pass with no such edge.
- R6: Ratio OK becomes 1 at a frame edge when two things hold:
  - the number of bit-clock rising edges in the frame just ended is 2^k for RATIO_MIN_LOG2 ≤ k ≤ RATIO_MAX_LOG2;
  - that number equals the previous frame's count.
  Ratio OK is 0 for any other count, and it clears on a frame timeout. Ratio OK is never 1 while frame valid is 0.
- R7: PLL lock and SRAM-clear done follow their input levels after a two-stage synchronizer.
- R8: The PLL fault bit sets when the synchronized lock level goes from 1 to 0.
- R9: The frame fault bit sets when (frame valid AND ratio OK) goes from 1 to 0.
- R10: The bit-clock fault bit sets when bit-clock valid goes from 1 to 0.
- R11: A write of 1 to a fault bit clears that bit. A write of 0 leaves it unchanged.
- R12: A set event and a write-1 clear on the same fault bit in the same cycle leave the bit set.
- R13: Reads at any address other than BASE_ADDR return 0x00. Writes at other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcm_clk_in | input | 1 | PCM bit clock, asynchronous |
| frame_sync_in | input | 1 | Frame sync, asynchronous |
| pll_lock_in | input | 1 | PLL lock level |
| sram_clr_done_in | input | 1 | SRAM-clear complete level |
| reg_addr | input | ADDR_W | Register address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data; bits 7..5 clear faults |
| reg_rdata | output | 8 | Read data (status word or 0) |

## Verification
Most internal faults show up at the read port directly.
- A miscounting edge counter or window comparator shows as a wrong bit-clock valid bit. This appears within two measurement windows of a change in clock rate.
- A broken frame timer or ratio compare shows as a wrong bit 1 or bit 2 within one timeout or three frames.
- An edge detector of the wrong polarity, or a clear that wins over a set, leaves a sticky bit in the wrong state. That state persists and can be read at any later time, because only a write-1 clear moves a fault bit back to 0.

// File: rtl/chs_pkg.sv
package chs_pkg;
  typedef struct packed {
    logic pll_flt;
    logic frm_flt;
    logic clk_flt;
    logic sram_done;
    logic lock;
    logic ratio_ok;
    logic frm_ok;
    logic clk_ok;
  } chs_stat_t;

  localparam int unsigned SYNC_PCM  = 0;
  localparam int unsigned SYNC_FRM  = 1;
  localparam int unsigned SYNC_LOCK = 2;
  localparam int unsigned SYNC_SRAM = 3;
  localparam int unsigned SYNC_NUM  = 4;
endpackage

// File: rtl/chs_sync.sv
module chs_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [STAGES:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-1:0], d};
  end

  assign q   = stg[STAGES-1];
  assign q_d = stg[STAGES];
endmodule

// File: rtl/chs_rate_meter.sv
module chs_rate_meter #(
  parameter int unsigned WINDOW_CYC = 62500,
  parameter int unsigned MIN_EDGES  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_in,
  output logic rate_ok
);
  localparam int unsigned WC_W = $clog2(WINDOW_CYC);
  localparam int unsigned EC_W = $clog2(MIN_EDGES + 1);

  logic [WC_W-1:0] win_cnt;
  logic [EC_W-1:0] edge_cnt, edge_nxt;
  logic            win_end;

  assign win_end  = (win_cnt == WC_W'(WINDOW_CYC - 1));
  assign edge_nxt = (edge_in && edge_cnt != EC_W'(MIN_EDGES)) ? edge_cnt + EC_W'(1) : edge_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      rate_ok  <= 1'b0;
    end else if (win_end) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      rate_ok  <= (edge_nxt == EC_W'(MIN_EDGES));
    end else begin
      win_cnt  <= win_cnt + WC_W'(1);
      edge_cnt <= edge_nxt;
    end
  end
endmodule

// File: rtl/chs_frame_watch.sv
module chs_frame_watch #(
  parameter int unsigned TIMEOUT_CYC    = 62500,
  parameter int unsigned RATIO_MIN_LOG2 = 4,
  parameter int unsigned RATIO_MAX_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_edge,
  input  logic clk_edge,
  output logic frm_ok,
  output logic ratio_ok
);
  localparam int unsigned TM_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned CNT_W = RATIO_MAX_LOG2 + 2;

  logic [TM_W-1:0]  timer;
  logic [CNT_W-1:0] cnt, meas, last_meas;
  logic             have_last, timeout;
  logic [RATIO_MAX_LOG2:RATIO_MIN_LOG2] pow_hit;

  assign meas    = (clk_edge && cnt != '1) ? cnt + CNT_W'(1) : cnt;
  assign timeout = !frm_edge && (timer >= TM_W'(TIMEOUT_CYC - 1));

  for (genvar k = RATIO_MIN_LOG2; k <= RATIO_MAX_LOG2; k++) begin : g_pow
    assign pow_hit[k] = (meas == CNT_W'(1 << k));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer     <= '0;
      cnt       <= '0;
      last_meas <= '0;
      have_last <= 1'b0;
      frm_ok    <= 1'b0;
      ratio_ok  <= 1'b0;
    end else if (frm_edge) begin
      timer     <= '0;
      cnt       <= '0;
      last_meas <= meas;
      have_last <= 1'b1;
      frm_ok    <= 1'b1;
      ratio_ok  <= (|pow_hit) && have_last && (meas == last_meas);
    end else begin
      cnt <= meas;
      if (timer != TM_W'(TIMEOUT_CYC)) timer <= timer + TM_W'(1);
      if (timeout) begin
        frm_ok    <= 1'b0;
        ratio_ok  <= 1'b0;
        have_last <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clk_health_status.sv
module clk_health_status #(
  parameter int unsigned    ADDR_W         = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h10,
  parameter int unsigned    WINDOW_CYC     = 62500,
  parameter int unsigned    MIN_EDGES      = 32,
  parameter int unsigned    FS_TIMEOUT_CYC = 62500,
  parameter int unsigned    RATIO_MIN_LOG2 = 4,
  parameter int unsigned    RATIO_MAX_LOG2 = 8
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              pcm_clk_in,
  input  logic              frame_sync_in,
  input  logic              pll_lock_in,
  input  logic              sram_clr_done_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  import chs_pkg::*;

  logic [SYNC_NUM-1:0] s_in, s_q, s_qd;
  logic pcm_rise, frm_rise, lock_fall;
  logic clk_ok, frm_ok, ratio_ok, frm_good;
  logic clk_ok_q, frm_good_q;
  logic [2:0] flt_q, flt_set, flt_clr;
  logic addr_hit;
  chs_stat_t stat_word;
  logic unused_bits;

  assign s_in[SYNC_PCM]  = pcm_clk_in;
  assign s_in[SYNC_FRM]  = frame_sync_in;
  assign s_in[SYNC_LOCK] = pll_lock_in;
  assign s_in[SYNC_SRAM] = sram_clr_done_in;

  chs_sync #(.W(SYNC_NUM), .STAGES(2)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(s_in), .q(s_q), .q_d(s_qd)
  );

  assign pcm_rise  = s_q[SYNC_PCM] & ~s_qd[SYNC_PCM];
  assign frm_rise  = s_q[SYNC_FRM] & ~s_qd[SYNC_FRM];
  assign lock_fall = s_qd[SYNC_LOCK] & ~s_q[SYNC_LOCK];

  chs_rate_meter #(.WINDOW_CYC(WINDOW_CYC), .MIN_EDGES(MIN_EDGES)) u_rate (
    .clk(clk_ref), .rst_n(rst_n), .edge_in(pcm_rise), .rate_ok(clk_ok)
  );

  chs_frame_watch #(
    .TIMEOUT_CYC(FS_TIMEOUT_CYC),
    .RATIO_MIN_LOG2(RATIO_MIN_LOG2),
    .RATIO_MAX_LOG2(RATIO_MAX_LOG2)
  ) u_frame (
    .clk(clk_ref), .rst_n(rst_n), .frm_edge(frm_rise), .clk_edge(pcm_rise),
    .frm_ok(frm_ok), .ratio_ok(ratio_ok)
  );

  assign frm_good = frm_ok & ratio_ok;
  assign addr_hit = (reg_addr == BASE_ADDR);

  assign flt_set = {lock_fall, frm_good_q & ~frm_good, clk_ok_q & ~clk_ok};
  assign flt_clr = (reg_wr_en && addr_hit) ? reg_wdata[7:5] : 3'b000;

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      clk_ok_q   <= 1'b0;
      frm_good_q <= 1'b0;
      flt_q      <= '0;
    end else begin
      clk_ok_q   <= clk_ok;
      frm_good_q <= frm_good;
      flt_q      <= (flt_q & ~flt_clr) | flt_set;
    end
  end

  always_comb begin
    stat_word.pll_flt   = flt_q[2];
    stat_word.frm_flt   = flt_q[1];
    stat_word.clk_flt   = flt_q[0];
    stat_word.sram_done = s_q[SYNC_SRAM];
    stat_word.lock      = s_q[SYNC_LOCK];
    stat_word.ratio_ok  = ratio_ok;
    stat_word.frm_ok    = frm_ok;
    stat_word.clk_ok    = clk_ok;
  end

  assign reg_rdata   = addr_hit ? stat_word : 8'h00;
  assign unused_bits = ^{reg_wdata[4:0], s_qd[SYNC_SRAM]};
endmodule

// File: rtl/clk_health_status_chk.sv
module clk_health_status_chk #(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        stat
);
  logic hit, unused_chk;
  assign hit        = reg_wr_en && (reg_addr == BASE_ADDR);
  assign unused_chk = ^{reg_wdata[4:0], stat[4]};

  AST_PLL_FAULT_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[3]) |=> stat[7]); // R8
  AST_FRAME_FAULT_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[1] && stat[2]) |=> stat[6]); // R9
  AST_CLK_FAULT_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[0]) |=> stat[5]); // R10
  AST_CLEAR_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && reg_wdata[7] && !$fell(stat[3])) |=> !stat[7]); // R11
  AST_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[6] && !(hit && reg_wdata[6])) |=> stat[6]); // R11
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && reg_wdata[5] && $fell(stat[0])) |=> stat[5]); // R12
  AST_RATIO_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    stat[2] |-> stat[1]); // R6
  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr != BASE_ADDR && stat[7]) |=> stat[7]); // R13
endmodule

bind clk_health_status clk_health_status_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) chk_i (
  .clk(clk_ref), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
  .reg_wdata(reg_wdata), .stat(stat_word)
);

// File: tb/clk_health_status_tb_top.sv
`timescale 1ns/1ps
module clk_health_status_tb_top;
  localparam logic [7:0] BASE = 8'h3C;
  localparam int WIN = 256, MINE = 8, TMO = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pcm = 1'b0, fsy = 1'b0, lock = 1'b0, sram = 1'b0;
  logic [7:0] addr = BASE, wdata = 8'h00, rdata;
  logic wr = 1'b0;

  int checks = 0, fails = 0;
  int half = 4, flen = 16;
  bit fs_en = 1'b0, run = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  clk_health_status #(
    .ADDR_W(8), .BASE_ADDR(BASE), .WINDOW_CYC(WIN), .MIN_EDGES(MINE),
    .FS_TIMEOUT_CYC(TMO), .RATIO_MIN_LOG2(4), .RATIO_MAX_LOG2(6)
  ) dut_i (
    .clk_ref(clk), .rst_n(rst_n), .pcm_clk_in(pcm), .frame_sync_in(fsy),
    .pll_lock_in(lock), .sram_clr_done_in(sram), .reg_addr(addr),
    .reg_wr_en(wr), .reg_wdata(wdata), .reg_rdata(rdata)
  );

  // bit clock and frame generator
  initial begin
    int idx = 0;
    wait (run);
    @(negedge clk);
    forever begin
      pcm = 1'b1;
      fsy = fs_en && (idx == 0);
      repeat (half) @(negedge clk);
      pcm = 1'b0;
      fsy = 1'b0;
      repeat (half) @(negedge clk);
      idx = (idx + 1 >= flen) ? 0 : idx + 1;
    end
  end

  function automatic bit ratio_good(int r);
    return (r == 16) || (r == 32) || (r == 64);
  endfunction

  function automatic logic [7:0] live_word(bit s, bit l, bit rok, bit fok, bit cok);
    return {3'b000, s, l, rok, fok, cok};
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_at(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, rdata, exp);
    end
    addr = BASE;
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = BASE; wdata = 8'h00;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    wait_cyc(10);
    check_at(BASE, 8'h00, "R2 reset value");
    rst_n = 1'b1;
    lock = 1'b1;
    run = 1'b1;
    fs_en = 1'b1;
    wait_cyc(2500);
    check_at(BASE, 8'h0F, "R1 R4 R5 R6 R7 healthy word");
    check_at(8'h3D, 8'h00, "R13 foreign read");

    lock = 1'b0;
    wait_cyc(10);
    check_at(BASE, 8'h87, "R8 lock loss fault");
    reg_write(8'h3D, 8'h80);
    check_at(BASE, 8'h87, "R13 foreign write ignored");
    reg_write(BASE, 8'h7F);
    check_at(BASE, 8'h87, "R11 R3 write zero keeps, RO bits unchanged");
    reg_write(BASE, 8'h80);
    check_at(BASE, 8'h07, "R11 write one clears");
    lock = 1'b1;
    wait_cyc(10);
    check_at(BASE, 8'h0F, "R7 lock follows input");

    flen = 20;
    wait_cyc(2500);
    check_at(BASE, 8'h4B, "R9 R6 bad ratio");
    reg_write(BASE, 8'h40);
    check_at(BASE, 8'h0B, "R11 clear frame fault");
    flen = 16;
    wait_cyc(2500);
    check_at(BASE, 8'h0F, "R6 ratio restored");

    for (int i = 0; i < 8; i++) begin
      int rl[6] = '{16, 20, 24, 32, 48, 64};
      int r = rl[$urandom_range(0, 5)];
      bit s = 1'($urandom_range(0, 1));
      flen = r;
      sram = s;
      wait_cyc(2500);
      reg_write(BASE, 8'hE0);
      wait_cyc(5);
      check_at(BASE, live_word(s, 1'b1, ratio_good(r), 1'b1, 1'b1), "R6 R7 random ratio");
    end

    sram = 1'b0;
    flen = 16;
    wait_cyc(2500);
    reg_write(BASE, 8'hE0);
    fs_en = 1'b0;
    wait_cyc(800);
    check_at(BASE, 8'h49, "R5 R9 frame timeout");
    reg_write(BASE, 8'h40);

    half = 16;
    wait_cyc(1000);
    reg_write(BASE, 8'hE0);
    check_at(BASE, 8'h09, "R4 exactly threshold edges stays valid");
    half = 20;
    wait_cyc(1000);
    check_at(BASE, 8'h28, "R4 R10 slow clock fault");

    half = 4;
    wait_cyc(1000);
    reg_write(BASE, 8'hE0);
    check_at(BASE, 8'h09, "R11 all clear");
    // lock falls, clear write lands in the cycle the fault sets
    @(negedge clk);
    lock = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr = BASE; wdata = 8'h80; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = 8'h00;
    check_at(BASE, 8'h81, "R12 set wins over clear");
    reg_write(BASE, 8'h80);
    check_at(BASE, 8'h01, "R11 later clear");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule